// File: doc/BRIEF.md
# PLL Multiplier Code Converter

This block translates between the plain binary feedback multiplier of a PLL and the scrambled 17-bit code that the PLL's divider register expects. The scrambled code is the state of a 15-bit linear feedback shift register. That state is reached by clocking the register forward from the seed 0x4000, one step for every value between the multiplier and the top of the range. Going the other way, the block clocks the register backwards until the seed comes back, and the number of steps gives the multiplier. Three low multipliers do not follow the register sequence. They are mapped by a fixed table instead.

In both directions the block also works out the two loop-bandwidth selector fields from the binary multiplier. It packs them with the code into one divider register word. Software or a sequencer pulses `start` with a direction on `mode` and an operand on `value_in`. The register advances one step per clock. When the conversion ends, `done` pulses for one cycle and the binary result and the packed word appear on the outputs. They stay there until the next conversion completes.

Top module: `pll_mcode_conv`

## Requirements
- R1: A `start` pulse while idle is accepted: `busy` is high from the next cycle. Completion is marked by a single-cycle `done` pulse in the same cycle in which `busy` falls. `msel_out` and `word_out` change only together with `done` and hold their values until the next `done`. `mode` = 0 selects encoding and `mode` = 1 selects decoding.
- R2: Encoding takes no steps for multipliers 0, 1 and 2, which give the codes 0x00000, 0x18003 and 0x10003.
- R3: Encoding any other multiplier M starts from the state 0x4000. For every M up to 32768 it makes one forward step per value from M to 32768 inclusive, that is 32769−M steps. A forward step shifts the state right by one and puts (bit0 XOR bit1) into bit 14. A multiplier above 32768 takes no steps and yields 0x4000.
- R4: Decoding maps the code 0x18003 to 1 and the code 0x10003 to 2, with no steps.
- R5: Decoding any other code starts a counter at 32769 and makes reverse steps, each decrementing the counter. A reverse step gives ((x<<1) & 0x7FFF) | ((x XOR x>>14) & 1). The counter stops when the state equals 0x4000 or the counter reaches 0, and its value is the result. So 0x4000 decodes to 32769 and an unreachable code decodes to 0.
- R6: The proportional selector is M/2+1 (integer division) when M is below 60, and 31 otherwise.
- R7: The integral selector is 1 for M>16384, 2 for M>8192, 4 for M>2048 and 8 for M≥501. For 60≤M≤500 it is 4·ceil(1024/(M+9)). Below 60 it is (M & 0x3C)+4.
- R8: `word_out` holds the code in bits [16:0], the proportional selector in [21:17] and the integral selector in [27:22], with bits [31:28] zero. Both selectors are computed from the binary multiplier.
- R9: A `start` pulse while `busy` is ignored: the running conversion keeps its operand, its direction and its cycle count.
- R10: After decoding, `msel_out` is the decoded multiplier and `word_out[16:0]` is the input code. After encoding, `msel_out` equals the input multiplier.
- R11: `done` rises exactly steps+1 clock edges after the edge that accepts `start`.
- R12: After reset, `busy`, `done`, `msel_out` and `word_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (ignored while busy) |
| mode | input | 1 | 0 = encode multiplier, 1 = decode code |
| value_in | input | 17 | Multiplier (encode) or code (decode) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| msel_out | output | 17 | Binary multiplier of the last conversion |
| word_out | output | 32 | Packed divider word of the last conversion |

## Verification
A corrupted shift-register state or step counter does not surface at the ports until `done`. It then shows up either as a wrong code or multiplier, or as a `done` pulse that arrives too early or too late. Because of this, every clock of a conversion is compared against a model that predicts the exact completion cycle, so a miscount is caught in the cycle where `done` should or should not appear. A bad selector value is visible in the packed word in the same cycle as `done`. Long runs near both ends of the range, the exact-division and threshold corners of the selectors, and an unreachable code all exercise paths that short runs would miss.

// File: rtl/pll_mcode_pkg.sv
package pll_mcode_pkg;
  localparam int LFSR_W   = 15;
  localparam int CODE_W   = 17;
  localparam int MSEL_W   = 17;
  localparam int SELP_W   = 5;
  localparam int SELI_W   = 6;
  localparam int WORD_W   = 32;
  localparam int SELP_LSB = CODE_W;
  localparam int SELI_LSB = SELP_LSB + SELP_W;
  localparam int PAD_W    = WORD_W - SELI_LSB - SELI_W;
  localparam int DIV_W    = 11;

  localparam logic [CODE_W-1:0] SEED     = CODE_W'(17'h04000);
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(17'h18003);
  localparam logic [CODE_W-1:0] CODE_TWO = CODE_W'(17'h10003);
  localparam logic [MSEL_W-1:0] MSEL_TOP = MSEL_W'(32768);
  localparam logic [MSEL_W-1:0] DEC_INIT = MSEL_W'(32769);

  typedef enum logic {OP_ENC = 1'b0, OP_DEC = 1'b1} op_e;

  // one forward step: shift right, feedback of bit0^bit1 into the top bit
  function automatic logic [CODE_W-1:0] step_fwd(input logic [CODE_W-1:0] x);
    logic [CODE_W-1:0] y;
    y = '0;
    y[LFSR_W-2:0] = x[LFSR_W-1:1];
    y[LFSR_W-1]   = x[0] ^ x[1];
    return y;
  endfunction

  // one reverse step: shift left within 15 bits, feedback of bit0^bit14
  function automatic logic [CODE_W-1:0] step_rev(input logic [CODE_W-1:0] x);
    logic [CODE_W-1:0] y;
    y = '0;
    y[LFSR_W-1:1] = x[LFSR_W-2:0];
    y[0]          = x[0] ^ x[LFSR_W-1];
    return y;
  endfunction

  function automatic logic [CODE_W-1:0] special_code(input logic [MSEL_W-1:0] m);
    if (m == '0) return '0;
    else if (m == MSEL_W'(1)) return CODE_ONE;
    else return CODE_TWO;
  endfunction

  function automatic logic [SELP_W-1:0] selp_of(input logic [MSEL_W-1:0] m);
    if (m < MSEL_W'(60)) return SELP_W'(m[5:1]) + SELP_W'(1);
    else return SELP_W'(31);
  endfunction

  function automatic logic [SELI_W-1:0] seli_of(input logic [MSEL_W-1:0] m);
    logic [DIV_W-1:0] den, quo, rem;
    den = DIV_W'(m) + DIV_W'(9);
    quo = DIV_W'(1024) / den;
    rem = DIV_W'(1024) % den;
    if (m > MSEL_W'(16384))     return SELI_W'(1);
    else if (m > MSEL_W'(8192)) return SELI_W'(2);
    else if (m > MSEL_W'(2048)) return SELI_W'(4);
    else if (m >= MSEL_W'(501)) return SELI_W'(8);
    else if (m >= MSEL_W'(60)) begin
      if (rem == '0) return SELI_W'({quo[3:0], 2'b00});
      else           return SELI_W'({quo[3:0] + 4'd1, 2'b00});
    end
    else return SELI_W'({m[5:2], 2'b00}) + SELI_W'(4);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] code,
                                                  input logic [SELP_W-1:0] selp,
                                                  input logic [SELI_W-1:0] seli);
    return {{PAD_W{1'b0}}, seli, selp, code};
  endfunction
endpackage

// File: rtl/pll_mcode_lfsr.sv
module pll_mcode_lfsr
  import pll_mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_e               load_op,
  input  logic [MSEL_W-1:0] load_val,
  input  logic              run,
  input  op_e               run_op,
  output logic [CODE_W-1:0] state,
  output logic [MSEL_W-1:0] count,
  output logic              special,
  output logic              finish,
  output logic              stepping
);
  logic done_enc, done_dec;

  assign done_enc = count > MSEL_TOP;
  assign done_dec = (state == SEED) || (count == '0);
  assign finish   = run && (special || ((run_op == OP_ENC) ? done_enc : done_dec));
  assign stepping = run && !finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= '0;
      count   <= '0;
      special <= 1'b0;
    end else if (load) begin
      if (load_op == OP_ENC) begin
        state   <= SEED;
        count   <= load_val;
        special <= load_val <= MSEL_W'(2);
      end else begin
        state   <= CODE_W'(load_val);
        count   <= DEC_INIT;
        special <= (CODE_W'(load_val) == CODE_ONE) || (CODE_W'(load_val) == CODE_TWO);
      end
    end else if (stepping) begin
      if (run_op == OP_ENC) begin
        state <= step_fwd(state);
        count <= count + MSEL_W'(1);
      end else begin
        state <= step_rev(state);
        count <= count - MSEL_W'(1);
      end
    end
  end
endmodule

// File: rtl/pll_mcode_bw.sv
module pll_mcode_bw
  import pll_mcode_pkg::*;
(
  input  logic [MSEL_W-1:0] msel,
  output logic [SELP_W-1:0] selp,
  output logic [SELI_W-1:0] seli
);
  always_comb begin
    selp = selp_of(msel);
    seli = seli_of(msel);
  end
endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pll_mcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [MSEL_W-1:0] value_in,
  output logic              busy,
  output logic              done,
  output logic [MSEL_W-1:0] msel_out,
  output logic [WORD_W-1:0] word_out
);
  op_e               op_q;
  logic [MSEL_W-1:0] val_q;
  logic              busy_q, done_q;
  logic [MSEL_W-1:0] msel_q;
  logic [WORD_W-1:0] word_q;

  // named internal events for the checker
  logic              accept_w, finish_w, step_w, special_w, op_dec_w;
  logic [CODE_W-1:0] st_w;
  logic [MSEL_W-1:0] cnt_w;

  logic [MSEL_W-1:0] res_msel;
  logic [CODE_W-1:0] res_code;
  logic [SELP_W-1:0] res_selp;
  logic [SELI_W-1:0] res_seli;
  op_e               mode_op;

  assign mode_op  = mode ? OP_DEC : OP_ENC;
  assign accept_w = start && !busy_q;
  assign op_dec_w = (op_q == OP_DEC);

  pll_mcode_lfsr u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_w),
    .load_op  (mode_op),
    .load_val (value_in),
    .run      (busy_q),
    .run_op   (op_q),
    .state    (st_w),
    .count    (cnt_w),
    .special  (special_w),
    .finish   (finish_w),
    .stepping (step_w)
  );

  always_comb begin
    if (op_q == OP_ENC) begin
      res_msel = val_q;
      res_code = special_w ? special_code(val_q) : st_w;
    end else begin
      res_code = CODE_W'(val_q);
      if (special_w) res_msel = (CODE_W'(val_q) == CODE_ONE) ? MSEL_W'(1) : MSEL_W'(2);
      else           res_msel = cnt_w;
    end
  end

  pll_mcode_bw u_bw (
    .msel (res_msel),
    .selp (res_selp),
    .seli (res_seli)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ENC;
      val_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      msel_q <= '0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        op_q   <= mode_op;
        val_q  <= value_in;
        busy_q <= 1'b1;
      end else if (finish_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        msel_q <= res_msel;
        word_q <= pack_word(res_code, res_selp, res_seli);
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign msel_out = msel_q;
  assign word_out = word_q;
endmodule

// File: rtl/pll_mcode_conv_chk.sv
module pll_mcode_conv_chk
  import pll_mcode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic              finish,
  input logic              op_dec,
  input logic [MSEL_W-1:0] cnt,
  input logic [CODE_W-1:0] st,
  input logic [MSEL_W-1:0] msel_out,
  input logic [WORD_W-1:0] word_out
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(word_out) && $stable(msel_out)));

  assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);

  assert_enc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && !op_dec) |=> (cnt == $past(cnt) + MSEL_W'(1)));

  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish && op_dec) |=> ((cnt == $past(cnt) - MSEL_W'(1)) && (st[CODE_W-1:LFSR_W] == '0)));

  assert_pack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((word_out[WORD_W-1:SELI_LSB+SELI_W] == '0) &&
              (word_out[SELI_LSB +: SELI_W] != '0) &&
              (word_out[SELP_LSB +: SELP_W] != '0)));

  assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_dec && (msel_out == '0)) |-> (word_out[CODE_W-1:0] == '0));
endmodule

bind pll_mcode_conv pll_mcode_conv_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .accept   (accept_w),
  .finish   (finish_w),
  .op_dec   (op_dec_w),
  .cnt      (cnt_w),
  .st       (st_w),
  .msel_out (msel_out),
  .word_out (word_out)
);

// File: tb/pll_mcode_conv_bench.sv
`timescale 1ns/1ps
module pll_mcode_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [16:0] value_in = '0;
  logic        busy, done;
  logic [16:0] msel_out;
  logic [31:0] word_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pll_mcode_conv u_pll_mcode_conv (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .value_in (value_in),
    .busy     (busy),
    .done     (done),
    .msel_out (msel_out),
    .word_out (word_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    summary();
  end

  // ---------------- behavioural reference ----------------
  function automatic int ref_fwd(input int x);
    return ((x >> 1) | (((x ^ (x >> 1)) & 1) << 14)) & 32'h7fff;
  endfunction

  function automatic int ref_rev(input int x);
    return ((x << 1) & 32'h7fff) | ((x ^ (x >> 14)) & 1);
  endfunction

  task automatic ref_encode(input int m, output int code, output int steps);
    steps = 0;
    if (m == 0)      code = 0;
    else if (m == 1) code = 32'h18003;
    else if (m == 2) code = 32'h10003;
    else begin
      code = 32'h4000;
      for (int i = m; i <= 32768; i++) begin
        code = ref_fwd(code);
        steps++;
      end
    end
  endtask

  task automatic ref_decode(input int c, output int m, output int steps);
    int x;
    steps = 0;
    if (c == 32'h18003)      m = 1;
    else if (c == 32'h10003) m = 2;
    else begin
      x = c;
      m = 32769;
      while (x != 32'h4000 && m > 0) begin
        x = ref_rev(x);
        m--;
        steps++;
      end
    end
  endtask

  function automatic int ref_selp(input int m);
    return (m < 60) ? (m / 2 + 1) : 31;
  endfunction

  function automatic int ref_seli(input int m);
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60)   return 4 * ((1024 + m + 8) / (m + 9));
    return (m & 32'h3c) + 4;
  endfunction

  // run one conversion, comparing busy/done every clock
  task automatic run_op(input bit m, input int v, input string req, input int inject);
    int exp_m, exp_code, steps, exp_word, bad_at;
    bit bad;
    if (m == 1'b0) begin
      ref_encode(v, exp_code, steps);
      exp_m = v;
    end else begin
      ref_decode(v, exp_m, steps);
      exp_code = v;
    end
    exp_word = exp_code | (ref_selp(exp_m) << 17) | (ref_seli(exp_m) << 22);
    @(negedge clk);
    start = 1'b1; mode = m; value_in = 17'(v);
    @(negedge clk);
    start = 1'b0; value_in = '0;
    bad = 1'b0; bad_at = -1;
    for (int j = 0; j <= steps; j++) begin
      if (j == inject) begin
        start = 1'b1; mode = ~m; value_in = 17'h00005;
      end else begin
        start = 1'b0;
      end
      if (busy !== 1'b1 || done !== 1'b0) begin
        if (!bad) bad_at = j;
        bad = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0; mode = 1'b0;
    chk(!bad, {req, " R11"}, "busy/done profile, first bad cycle", bad_at, -1);
    chk(done === 1'b1 && busy === 1'b0, {req, " R11"}, "done/busy at completion",
        {done, busy}, 2'b10);
    chk(msel_out === 17'(exp_m), {req, " R10"}, "msel_out", msel_out, exp_m);
    chk(word_out === exp_word, {req, " R8"}, "word_out", word_out, exp_word);
    @(negedge clk);
    chk(done === 1'b0 && word_out === exp_word && msel_out === 17'(exp_m), "R1",
        "pulse ends and outputs hold", word_out, exp_word);
  endtask

  initial begin
    int c, s;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && msel_out === '0 && word_out === '0,
        "R12", "reset state", word_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && word_out === '0, "R12", "idle after reset",
        {busy, done}, 0);

    run_op(1'b0, 0, "R2 R6 R7", -1);
    run_op(1'b0, 1, "R2 R6", -1);
    run_op(1'b0, 2, "R2 R6", -1);
    run_op(1'b1, 32'h18003, "R4", -1);
    run_op(1'b1, 32'h10003, "R4 R10", -1);
    run_op(1'b0, 32768, "R3", -1);
    run_op(1'b1, 32'h2000, "R5", -1);
    run_op(1'b0, 40000, "R3 R7", -1);
    run_op(1'b1, 32'h4000, "R5 R6", -1);
    run_op(1'b0, 32700, "R3", -1);
    ref_encode(32700, c, s);
    run_op(1'b1, c, "R5 R10", -1);
    run_op(1'b0, 16385, "R3 R7", -1);
    ref_encode(16384, c, s);
    run_op(1'b1, c, "R5 R7", -1);
    run_op(1'b0, 60, "R6 R7 R9", 100);
    run_op(1'b0, 119, "R7", 5);
    run_op(1'b1, 0, "R5", -1);
    summary();
  end
endmodule